// File: doc/BRIEF.md
# Programmable Decade Frequency Divider

This block divides a clock by a decimal divisor. The divisor arrives as one BCD digit per decade, and the decades form a chain of down-counters that share a single clock. Each decade borrows from the next more significant decade. That decade steps only when every decade below it holds zero. When the whole chain is at zero it raises a terminal event and drives the output pulse low. On the next edge the chain reloads the divisor, and the divisor is counted down in that same step, so one full cycle takes exactly N input clocks.

A divisor of zero is a special case. The chain freezes where it is and the output stays high. A divisor of one keeps the output low on every cycle. The divisor is sampled only when the chain reloads, so it can change at any time without breaking the period that is in progress. The number of decades is a parameter.

Top module: `bcd_decade_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the output is high. Reset clears every decade. The divisor is first taken at the first clock edge after release, and the first low output appears after exactly N edges.
- R2: Digit i of the divisor sits in bits [4i+3:4i], and N is the sum of digit i times 10 to the power i. For N of 2 or more, the output goes low once every N input clocks.
- R3: For N of 2 or more, each low pulse of the output lasts exactly one clock cycle.
- R4: With N equal to 1, the output is low in every cycle from the first edge after reset onward.
- R5: With every divisor digit at zero, the output stays high and the chain holds its state. When a nonzero divisor returns, counting resumes from the held state.
- R6: A change of divisor in the middle of a period does not alter that period. The new value is used from the next reload onward.
- R7: A decade steps only when all less significant decades hold zero, and in that step it goes from 0 to 9. No decade ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| divisor_bcd | input | 4*DIGITS | Divisor, one BCD digit per decade, least significant digit in the low bits |
| div_out_n | output | 1 | Divided output, low for one cycle at each terminal event |

## Verification
The bench builds the block with three decades. That reaches divisors from 1 to 999, including the values where a borrow ripples across two decades (100, 305) and the largest value (999). Every cycle, a behavioural counter model that works on plain integers predicts the output. On top of that, measured periods are checked for a set of divisors, and specific checks cover divisor changes in the middle of a period, a zero divisor and a divisor of one.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   typedef logic [3:0] bcd_digit_t;

   localparam bcd_digit_t BCD_TOP = 4'd9;

   // One decimal step downward, wrapping 0 to 9.
   function automatic bcd_digit_t bcd_step_down(input bcd_digit_t d);
      return (d == '0) ? BCD_TOP : bcd_digit_t'(d - 4'd1);
   endfunction

endpackage

// File: rtl/fdiv_zero_detect.sv
module fdiv_zero_detect #(
   parameter int DIGITS = 3,
   localparam int W = 4 * DIGITS
) (
   input  logic [W-1:0] digits,
   output logic         all_zero
);
   logic [DIGITS-1:0] digit_zero;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assign digit_zero[g] = (digits[4*g +: 4] == 4'd0);
   end

   assign all_zero = &digit_zero;
endmodule

// File: rtl/fdiv_decade.sv
module fdiv_decade
   import fdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  bcd_digit_t preset_digit,
   input  logic       reload,
   input  logic       count_en,
   output bcd_digit_t digit_q,
   output logic       borrow_out
);
   bcd_digit_t base_d;
   bcd_digit_t next_d;

   always_comb begin
      base_d = reload ? preset_digit : digit_q;
      next_d = count_en ? bcd_step_down(base_d) : base_d;
   end

   // Next decade may step only when this one wraps from zero.
   assign borrow_out = count_en & (base_d == '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) digit_q <= '0;
      else     digit_q <= next_d;
   end
endmodule

// File: rtl/bcd_decade_divider.sv
module bcd_decade_divider
   import fdiv_pkg::*;
#(
   parameter int DIGITS = 3,
   localparam int W = 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] divisor_bcd,
   output logic         div_out_n
);
   if (DIGITS < 1 || DIGITS > 9) begin : g_bad_digits
      $error("bcd_decade_divider: DIGITS must lie in 1..9");
   end

   logic [W-1:0]    chain_q;
   logic [DIGITS:0] enable_chain;
   logic            divisor_zero;
   logic            chain_zero;
   logic            run;
   logic            fresh_q;
   logic            reload;

   fdiv_zero_detect #(.DIGITS(DIGITS)) u_div_zero (
      .digits   (divisor_bcd),
      .all_zero (divisor_zero)
   );

   fdiv_zero_detect #(.DIGITS(DIGITS)) u_chain_zero (
      .digits   (chain_q),
      .all_zero (chain_zero)
   );

   assign run             = ~divisor_zero;
   assign reload          = run & (fresh_q | chain_zero);
   assign enable_chain[0] = run;

   for (genvar g = 0; g < DIGITS; g++) begin : g_decade
      fdiv_decade u_decade (
         .clk          (clk),
         .rst          (rst),
         .preset_digit (divisor_bcd[4*g +: 4]),
         .reload       (reload),
         .count_en     (enable_chain[g]),
         .digit_q      (chain_q[4*g +: 4]),
         .borrow_out   (enable_chain[g+1])
      );
   end

   // Marks the state right after reset, before the divisor has been taken.
   always_ff @(posedge clk or posedge rst) begin
      if (rst)      fresh_q <= 1'b1;
      else if (run) fresh_q <= 1'b0;
   end

   assign div_out_n = ~(run & ~fresh_q & chain_zero);
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
   parameter int DIGITS = 3,
   localparam int W = 4 * DIGITS
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] divisor_bcd,
   input logic         div_out_n,
   input logic [W-1:0] chain_q
);
   localparam logic [W-1:0] DIV_ONE = W'(1);

   a_r1_release_high: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> div_out_n);

   a_r5_zero_out_high: assert property (@(posedge clk) disable iff (rst)
      (divisor_bcd == '0) |-> div_out_n);

   a_r5_zero_hold: assert property (@(posedge clk) disable iff (rst)
      (divisor_bcd == '0) |=> $stable(chain_q));

   a_r3_single_low: assert property (@(posedge clk) disable iff (rst)
      (!div_out_n && divisor_bcd != DIV_ONE) |=> div_out_n);

   for (genvar g = 0; g < DIGITS; g++) begin : g_legal
      a_r7_digit_legal: assert property (@(posedge clk) disable iff (rst)
         chain_q[4*g +: 4] <= 4'd9);
   end
endmodule

bind bcd_decade_divider fdiv_checker #(.DIGITS(DIGITS)) u_fdiv_checker (
   .clk         (clk),
   .rst         (rst),
   .divisor_bcd (divisor_bcd),
   .div_out_n   (div_out_n),
   .chain_q     (chain_q)
);

// File: tb/bcd_decade_divider_tb_top.sv
`timescale 1ns/1ps
module bcd_decade_divider_tb_top;
   localparam int DIGITS = 3;
   localparam int W = 4 * DIGITS;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] div_bcd = '0;
   logic         out_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bcd_decade_divider #(.DIGITS(DIGITS)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .divisor_bcd (div_bcd),
      .div_out_n   (out_n)
   );

   function automatic int bcd_value(input logic [W-1:0] b);
      int v = 0;
      for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
      return v;
   endfunction

   function automatic logic [W-1:0] to_bcd(input int n);
      logic [W-1:0] r = '0;
      int v = n;
      for (int i = 0; i < DIGITS; i++) begin
         r[4*i +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Behavioural reference: integer count, fresh flag after reset.
   int m_cnt;
   int m_n;
   bit m_fresh;
   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_fresh = 1'b1;
         m_cnt   = 0;
      end else begin
         m_n = bcd_value(div_bcd);
         if (m_n != 0) begin
            m_cnt   = ((m_fresh || m_cnt == 0) ? m_n : m_cnt) - 1;
            m_fresh = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         automatic bit exp_out = !(bcd_value(div_bcd) != 0 && !m_fresh && m_cnt == 0);
         chk(out_n == exp_out, "R2 per-cycle model", int'(out_n), int'(exp_out));
      end
   end

   int wf, ws, wl;

   task automatic watch(input int len);
      wf = -1; ws = -1; wl = 0;
      for (int k = 1; k <= len; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (!out_n) begin
            wl++;
            if (wf < 0) wf = k;
            else if (ws < 0) ws = k;
         end
      end
   endtask

   task automatic do_reset(input int n);
      @(posedge clk); #5;
      rst = 1'b1;
      div_bcd = to_bcd(n);
      @(negedge clk);
      chk(out_n == 1'b1, "R1 high in reset", int'(out_n), 1);
      @(posedge clk); #5;
      rst = 1'b0;
      @(negedge clk);
      chk(out_n == 1'b1, "R1 high after release", int'(out_n), 1);
   endtask

   task automatic set_div(input int n);
      @(posedge clk); #5;
      div_bcd = to_bcd(n);
   endtask

   task automatic per_test(input int n, input string tag);
      do_reset(n);
      watch(2 * n + 1);
      chk(wf == n, {tag, " R1 first low"}, wf, n);
      chk(ws - wf == n, {tag, " R2 period"}, ws - wf, n);
      chk(wl == 2, {tag, " R3 one-cycle pulses"}, wl, 2);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      per_test(2,   "R2");
      per_test(7,   "R2");
      per_test(9,   "R2");
      per_test(10,  "R2/R7");
      per_test(45,  "R2/R7");
      per_test(100, "R2/R7");
      per_test(305, "R2/R7");
      per_test(999, "R2/R7");

      // R4: divisor one keeps the output low every cycle
      do_reset(1);
      watch(20);
      chk(wf == 1, "R4 first low", wf, 1);
      chk(wl == 20, "R4 always low", wl, 20);

      // R5: zero divisor from reset, then a nonzero one
      do_reset(0);
      watch(30);
      chk(wl == 0, "R5 zero divisor high", wl, 0);
      set_div(4);
      watch(10);
      chk(wf == 4, "R5 start from fresh", wf, 4);

      // R5: zero in mid-run freezes the chain at 3
      do_reset(6);
      watch(2);
      set_div(0);
      watch(10);
      chk(wl == 0, "R5 frozen high", wl, 0);
      set_div(6);
      watch(6);
      chk(wf == 3, "R5 resume from held state", wf, 3);

      // R6: change in mid-period applies at next reload
      do_reset(5);
      watch(2);
      set_div(3);
      watch(8);
      chk(wf == 2, "R6 current period kept", wf, 2);
      chk(ws - wf == 3, "R6 new period after reload", ws - wf, 3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule